// File: doc/BRIEF.md
# Pattern-Memory Self-Test Controller

This block adds a built-in self-test to a small six-input, one-output combinational unit. In functional mode, the unit sees the external 6-bit input, and its result appears on the output at once. The block starts a test run when a one-cycle request arrives while it is idle. At that request it latches a 2-bit fault-select code that stays fixed for the whole run. It then cuts the external input off from the unit and drives the unit instead from a pattern store. Each stored word packs a stimulus and the response a healthy unit must produce.

A sequencer steps through the stored vectors in address order. Each vector takes two cycles: one to present the address, and one to compare the unit's output with the stored expected bit. This gives the pattern store room for a registered read port. On the first mismatch the sequencer freezes. It raises a sticky error flag, reports the address of the failing vector, and keeps that vector applied until reset. If every vector matches, the block returns to functional mode by itself with a clear error flag and an ID of zero. The included unit carries a fault hook, so each of the three selectable defects can be exercised.

Top module: `cbist_top`

## Requirements
- R1: While rst_n is low and after its release, err_flag is 0, fail_id is 0, test_mode is 0 and the latched fault code is 00 (no fault).
- R2: With test_mode at 0, uut_out equals the unit function of func_in in the same cycle, using the latched fault code. Writing the input bits as x[5:0] = func_in, the unit function is y = NOR(x[1], x[0]) OR (x[5] AND x[4] AND (x[3] OR x[2])).
- R3: The fault codes act inside the unit as follows: 00 has no effect, 01 holds x[1] at 1, 10 holds the term (x[3] OR x[2]) at 0, and 11 holds x[0] at 0.
- R4: When test_req is 1 at a rising edge while the block is idle, the block copies fault_sel into the fault latch and test_mode is 1 after that edge. At any other time, fault_sel has no effect.
- R5: The pattern store holds eight 7-bit words, at addresses 0 to 7: 0x69, 0x02, 0x71, 0x75, 0x01, 0x19, 0x56, 0x2C. Bits [6:1] of a word are the stimulus x[5:0] and bit 0 is the expected output. During a run the unit sees only the stored stimulus.
- R6: If the run starts at edge k, vector i is applied to the unit after edge k+1+2i and compared at edge k+2+2i.
- R7: On the first mismatch, found at vector n, err_flag is 1 and fail_id equals n after edge k+2+2n. The sequencer then stops, and uut_out keeps showing the unit's response to vector n.
- R8: Once err_flag is 1, it stays 1, and fail_id, test_mode and uut_out keep their values until reset. test_req, fault_sel and func_in have no effect during this time.
- R9: If all vectors match, test_mode falls after edge k+16, with err_flag 0 and fail_id 0. uut_out then follows func_in again.
- R10: A test_req pulse during a run is ignored. The run ends at the same cycle with the same result as it would without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the test logic |
| func_in | input | 6 | Functional input to the unit under test |
| fault_sel | input | 2 | Fault-select code, latched at test start |
| test_req | input | 1 | One-cycle request to start a self-test run |
| uut_out | output | 1 | Output of the unit under test |
| test_mode | output | 1 | 1 while the unit is driven from the pattern store |
| err_flag | output | 1 | Sticky flag: the test found a mismatch |
| fail_id | output | 4 | Address of the vector that exposed the fault |

## Verification
The bench counts rising edges from the request edge k. It expects test_mode high after edge k, vector i on uut_out after edge k+1+2i, and the error flag with its ID after edge k+2+2n. On a clean run it expects test_mode low after edge k+16. All inputs change on the falling edge, and each result is sampled on the falling edge that follows the edge where it becomes due. Each result is therefore read half a cycle after the register feeding it has updated. The bench also samples once one cycle earlier, to prove that the error flag did not rise early. In functional mode, uut_out is checked half a clock after func_in changes, because that path has no register.

// File: rtl/cbist_pkg.sv
package cbist_pkg;

   localparam int unsigned STIM_W   = 6;
   localparam int unsigned WORD_W   = STIM_W + 1;
   localparam int unsigned STORE_SZ = 8;

   localparam logic [1:0] FLT_NONE   = 2'b00;
   localparam logic [1:0] FLT_X1_HI  = 2'b01;
   localparam logic [1:0] FLT_OR_LO  = 2'b10;
   localparam logic [1:0] FLT_X0_LO  = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_APPLY   = 3'd1,
      ST_COMPARE = 3'd2,
      ST_FAIL    = 3'd3,
      ST_PASS    = 3'd4
   } seq_state_t;

   // stimulus in bits [6:1], expected response in bit 0
   function automatic logic [WORD_W-1:0] pattern_word(int unsigned idx);
      logic [WORD_W-1:0] w;
      case (idx)
         0:       w = 7'h69;
         1:       w = 7'h02;
         2:       w = 7'h71;
         3:       w = 7'h75;
         4:       w = 7'h01;
         5:       w = 7'h19;
         6:       w = 7'h56;
         7:       w = 7'h2C;
         default: w = '0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/cbist_rom.sv
module cbist_rom
   import cbist_pkg::*;
#(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned AW       = 3,
   parameter bit          REG_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   output logic [WORD_W-1:0] word
);

   logic [WORD_W-1:0] lookup;

   always_comb begin
      if (32'(addr) < DEPTH) lookup = pattern_word(32'(addr));
      else                   lookup = '0;
   end

   generate
      if (REG_READ) begin : g_sync_read
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= lookup;
         end
         assign word = word_q;
      end else begin : g_async_read
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign word = lookup;
      end
   endgenerate

endmodule

// File: rtl/cbist_cut.sv
module cbist_cut
   import cbist_pkg::*;
(
   input  logic [STIM_W-1:0] x,
   input  logic [1:0]        fault,
   output logic              y
);

   logic [STIM_W-1:0] xf;
   logic              t_and;
   logic              t_or;
   logic              t_nor;

   always_comb begin
      xf = x;
      if (fault == FLT_X1_HI) xf[1] = 1'b1;
      if (fault == FLT_X0_LO) xf[0] = 1'b0;
   end

   assign t_and = xf[5] & xf[4];
   assign t_or  = (fault == FLT_OR_LO) ? 1'b0 : (xf[3] | xf[2]);
   assign t_nor = ~(xf[1] | xf[0]);
   assign y     = t_nor | (t_and & t_or);

endmodule

// File: rtl/cbist_seq.sv
module cbist_seq
   import cbist_pkg::*;
#(
   parameter int unsigned NUM_PAT = 8,
   parameter int unsigned AW      = 3,
   parameter int unsigned ID_W    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            test_req,
   input  logic [1:0]      fault_sel,
   input  logic            pat_exp,
   input  logic            cut_y,
   output logic [AW-1:0]   addr,
   output logic [1:0]      fault_q,
   output logic            test_mode,
   output logic            err_flag,
   output logic [ID_W-1:0] fail_id,
   output seq_state_t      state
);

   localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_PAT - 1);

   seq_state_t       st;
   logic [AW-1:0]    addr_q;
   logic [1:0]       fault_r;
   logic             err_q;
   logic [ID_W-1:0]  id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr_q  <= '0;
         fault_r <= FLT_NONE;
         err_q   <= 1'b0;
         id_q    <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (test_req) begin
                  fault_r <= fault_sel;
                  addr_q  <= '0;
                  st      <= ST_APPLY;
               end
            end
            ST_APPLY: st <= ST_COMPARE;
            ST_COMPARE: begin
               if (cut_y != pat_exp) begin
                  st    <= ST_FAIL;
                  err_q <= 1'b1;
                  id_q  <= ID_W'(addr_q);
               end else if (addr_q == LAST_ADDR) begin
                  st     <= ST_PASS;
                  addr_q <= '0;
               end else begin
                  addr_q <= addr_q + AW'(1);
                  st     <= ST_APPLY;
               end
            end
            ST_FAIL: st <= ST_FAIL;
            ST_PASS: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign addr      = addr_q;
   assign fault_q   = fault_r;
   assign err_flag  = err_q;
   assign fail_id   = id_q;
   assign state     = st;
   assign test_mode = (st == ST_APPLY) || (st == ST_COMPARE) || (st == ST_FAIL);

endmodule

// File: rtl/cbist_top.sv
module cbist_top
   import cbist_pkg::*;
#(
   parameter int unsigned IN_W     = 6,
   parameter int unsigned NUM_PAT  = 8,
   parameter int unsigned ID_W     = 4,
   parameter bit          REG_READ = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IN_W-1:0] func_in,
   input  logic [1:0]      fault_sel,
   input  logic            test_req,
   output logic            uut_out,
   output logic            test_mode,
   output logic            err_flag,
   output logic [ID_W-1:0] fail_id
);

   localparam int unsigned AW    = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
   localparam int unsigned PAT_W = IN_W + 1;

   generate
      if (IN_W != STIM_W) begin : g_bad_in_w
         $error("cbist_top: IN_W must match the unit width");
      end
      if (NUM_PAT < 1 || NUM_PAT > STORE_SZ) begin : g_bad_num_pat
         $error("cbist_top: NUM_PAT outside the stored pattern range");
      end
      if (ID_W < AW) begin : g_bad_id_w
         $error("cbist_top: ID_W too narrow for the pattern address");
      end
   endgenerate

   logic [AW-1:0]    pat_addr;
   logic [PAT_W-1:0] pat_word;
   logic [1:0]       fault_q;
   logic [IN_W-1:0]  cut_x;
   logic             cut_y;
   seq_state_t       seq_state;

   cbist_rom #(
      .DEPTH    (NUM_PAT),
      .AW       (AW),
      .REG_READ (REG_READ)
   ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (pat_addr),
      .word  (pat_word)
   );

   cbist_seq #(
      .NUM_PAT (NUM_PAT),
      .AW      (AW),
      .ID_W    (ID_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_req  (test_req),
      .fault_sel (fault_sel),
      .pat_exp   (pat_word[0]),
      .cut_y     (cut_y),
      .addr      (pat_addr),
      .fault_q   (fault_q),
      .test_mode (test_mode),
      .err_flag  (err_flag),
      .fail_id   (fail_id),
      .state     (seq_state)
   );

   // input isolation: stored stimulus replaces the functional input in test
   assign cut_x = test_mode ? pat_word[PAT_W-1:1] : func_in;

   cbist_cut u_cut (
      .x     (cut_x),
      .fault (fault_q),
      .y     (cut_y)
   );

   assign uut_out = cut_y;

endmodule

// File: rtl/cbist_chk.sv
module cbist_chk
   import cbist_pkg::*;
#(
   parameter int unsigned ID_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            test_req,
   input logic            test_mode,
   input logic            err_flag,
   input logic [ID_W-1:0] fail_id,
   input logic [1:0]      fault_q,
   input seq_state_t      seq_state
);

   p_start_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_IDLE && test_req) |=> test_mode);

   p_fault_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> $stable(fault_q));

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> (err_flag && $stable(fail_id) && test_mode));

   p_err_in_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> test_mode);

   p_id_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !err_flag |-> (fail_id == '0));

   p_pass_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_PASS) |-> (!test_mode && !err_flag));

   p_idle_after_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_PASS) |=> (seq_state == ST_IDLE));

endmodule

bind cbist_top cbist_chk #(.ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_req  (test_req),
   .test_mode (test_mode),
   .err_flag  (err_flag),
   .fail_id   (fail_id),
   .fault_q   (fault_q),
   .seq_state (seq_state)
);

// File: tb/cbist_top_tb.sv
`timescale 1ns/1ps
module cbist_top_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] func_in = '0;
   logic [1:0] fault_sel = '0;
   logic       test_req = 1'b0;
   logic       uut_out;
   logic       test_mode;
   logic       err_flag;
   logic [3:0] fail_id;

   int n_run = 0;
   int n_fail = 0;
   logic [1:0] latched = 2'b00;

   always #2.5 clk = ~clk;

   cbist_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .func_in   (func_in),
      .fault_sel (fault_sel),
      .test_req  (test_req),
      .uut_out   (uut_out),
      .test_mode (test_mode),
      .err_flag  (err_flag),
      .fail_id   (fail_id)
   );

   function automatic logic [6:0] ref_word(int i);
      case (i)
         0: return 7'h69;
         1: return 7'h02;
         2: return 7'h71;
         3: return 7'h75;
         4: return 7'h01;
         5: return 7'h19;
         6: return 7'h56;
         default: return 7'h2C;
      endcase
   endfunction

   function automatic logic ref_out(logic [5:0] x, logic [1:0] f);
      logic [5:0] xx;
      logic a, o, n;
      xx = x;
      if (f == 2'b01) xx[1] = 1'b1;
      if (f == 2'b11) xx[0] = 1'b0;
      a = xx[5] & xx[4];
      o = (f == 2'b10) ? 1'b0 : (xx[3] | xx[2]);
      n = ~(xx[1] | xx[0]);
      return n | (a & o);
   endfunction

   function automatic int ref_fail(logic [1:0] f);
      for (int i = 0; i < 8; i++) begin
         logic [6:0] w;
         w = ref_word(i);
         if (ref_out(w[6:1], f) != w[0]) return i;
      end
      return 8;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      test_req = 1'b0;
      @(negedge clk);
      check("R1 err in reset", int'(err_flag), 0);
      check("R1 id in reset", int'(fail_id), 0);
      check("R1 mode in reset", int'(test_mode), 0);
      @(negedge clk);
      rst_n = 1'b1;
      latched = 2'b00;
      @(negedge clk);
      check("R1 err after reset", int'(err_flag), 0);
      check("R1 mode after reset", int'(test_mode), 0);
   endtask

   task automatic normal_checks(int count);
      for (int j = 0; j < count; j++) begin
         @(negedge clk);
         func_in   = 6'($urandom());
         fault_sel = 2'($urandom());
         #1;
         check("R2/R4 functional output", int'(uut_out), int'(ref_out(func_in, latched)));
      end
   endtask

   task automatic run_test(logic [1:0] f, bit mid_req);
      int n;
      logic [6:0] w;
      n = ref_fail(f);
      @(negedge clk);
      fault_sel = f;
      test_req  = 1'b1;
      @(negedge clk);             // edge k has passed
      test_req  = 1'b0;
      fault_sel = ~f;
      check("R4 test_mode after request", int'(test_mode), 1);
      latched = f;
      for (int i = 0; i < 8; i++) begin
         w = ref_word(i);
         @(negedge clk);          // after edge k+1+2i
         func_in = 6'($urandom());
         check("R5 stored stimulus applied", int'(uut_out), int'(ref_out(w[6:1], f)));
         check("R6 no early error", int'(err_flag), 0);
         if (mid_req && i == 1) begin
            test_req  = 1'b1;
            fault_sel = 2'($urandom());
         end
         @(negedge clk);          // after edge k+2+2i
         test_req = 1'b0;
         if (i == n) begin
            check("R7 error raised", int'(err_flag), 1);
            check("R7 failing id", int'(fail_id), n);
            check("R7 test_mode held", int'(test_mode), 1);
            break;
         end
         if (i == 7) begin
            check("R9 test_mode dropped", int'(test_mode), 0);
            check("R9 error clear", int'(err_flag), 0);
            check("R9 id zero", int'(fail_id), 0);
            check("R10 run length kept", n, 8);
         end else begin
            check("R6 run continues", int'(test_mode), 1);
         end
      end
      if (n < 8) begin
         w = ref_word(n);
         for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            test_req  = (j % 2) == 0;
            fault_sel = 2'($urandom());
            func_in   = 6'($urandom());
            #1;
            check("R8 error sticky", int'(err_flag), 1);
            check("R8 id frozen", int'(fail_id), n);
            check("R8 output frozen", int'(uut_out), int'(ref_out(w[6:1], f)));
         end
         do_reset();
      end else begin
         normal_checks(4);
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h0000_5EED));
      repeat (2) @(negedge clk);
      check("R1 err under reset", int'(err_flag), 0);
      check("R1 id under reset", int'(fail_id), 0);
      check("R1 mode under reset", int'(test_mode), 0);
      rst_n = 1'b1;
      normal_checks(30);
      // directed: every fault code, with and without a mid-run request
      run_test(2'b00, 1'b0);
      run_test(2'b01, 1'b0);
      run_test(2'b10, 1'b0);
      run_test(2'b11, 1'b0);
      run_test(2'b00, 1'b1);
      run_test(2'b11, 1'b1);
      // R3 direct: each code's expected detection address differs
      check("R3 fault 01 address", ref_fail(2'b01), 4);
      check("R3 fault 10 address", ref_fail(2'b10), 3);
      check("R3 fault 11 address", ref_fail(2'b11), 1);
      for (int r = 0; r < 12; r++) begin
         run_test(2'($urandom()), 1'($urandom()));
      end
      normal_checks(20);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule